// File: doc/BRIEF.md
# Slow-Channel Rate Code Persistence Filter

This block sits on the receive side of a radio-link framer. Once per hyperframe, one control byte is marked as the byte that carries the slow management channel rate. The low three bits of that byte form a rate code. A link can glitch, so a new code is not trusted when it first appears. The block takes a code only after it has arrived unchanged in a number of hyperframes in a row (four by default). When it takes a new code, it raises a one-cycle change pulse.

The block then turns the accepted code into a bit rate in kbps, using the configured line rate. Each fixed code needs a minimum line rate. If the line rate is too low, the code is flagged as unsupported and the resolved rate reads zero. The top code value does not name a fixed rate: it means "the fastest rate the current line rate allows". Code zero means the slow channel is absent. Software can load a starting code through a preload port. The transmit-side code is a separate configuration value that is passed straight through, with no filtering.

Top module: `slowch_rate_filter`

## Requirements
- R1: A code is sampled only in a cycle where `hf_slot` and `byte_vld` are both high. The code is bits [2:0] of `ctl_byte`. Bits [7:3] have no effect.
- R2: A sampled code is accepted once it has been sampled four times in a row. `rx_code` takes the new value at the clock edge that captures the fourth sample.
- R3: A sample that differs from the previous sample restarts the run at a count of one. An interrupted run of a code is not accepted.
- R4: `code_chg` is high for exactly the one cycle after an edge where `rx_code` takes a new value. A run that repeats the code already accepted gives no pulse.
- R5: After reset, `rx_code` is 0, `chan_en` is 0, `rate_kbps` is 0, `rate_unsup` is 0 and `code_chg` is 0.
- R6: `chan_en` is high exactly when `rx_code` is not 0. Code 0 always resolves to a rate of 0 and is never flagged unsupported.
- R7: Codes 1 to 6 resolve to 240, 480, 960, 1920, 2400 and 3840 kbps.
- R8: `line_sel` is decoded as follows:
  - 0 = 614.4 Mbps
  - 1 = 1228.8 Mbps
  - 2 = 2457.6 Mbps
  - 3 = 3072.0 Mbps
  - 4 = 4915.2 Mbps
  - 5 = 6144.0 Mbps
  - 6 = 9830.4 Mbps
  - 7 is treated as 6.

  Codes 1 and 2 need a setting of at least 0, code 3 at least 1, code 4 at least 2, code 5 at least 3 and code 6 at least 4. Below that minimum, `rate_unsup` is 1 and `rate_kbps` is 0.
- R9: Code 7 resolves to the top rate for the line setting. Settings 0 to 6 give 480, 960, 1920, 2400, 3840, 4800 and 7680 kbps. Code 7 is never unsupported.
- R10: `rate_kbps` and `rate_unsup` are registered. They follow a change of `rx_code` or `line_sel` one clock later.
- R11: A high `preload_en` loads `preload_code` into `rx_code` at the next edge and gives no `code_chg` pulse. It also clears the run count. It takes priority over a sample in the same cycle, and that sample is dropped.
- R12: `tx_code` equals `tx_cfg_code` at all times, whatever the receive filter is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_byte | input | 8 | Received control byte |
| byte_vld | input | 1 | Control byte is valid |
| hf_slot | input | 1 | Control byte is the designated rate byte of a hyperframe |
| line_sel | input | 3 | Configured line rate setting |
| preload_en | input | 1 | Load `preload_code` as the accepted code |
| preload_code | input | 3 | Initial accepted code |
| tx_cfg_code | input | 3 | Transmit rate code from configuration |
| rx_code | output | 3 | Accepted receive rate code |
| chan_en | output | 1 | Slow channel present |
| rate_kbps | output | 14 | Resolved bit rate in kbps, 0 when absent or unsupported |
| rate_unsup | output | 1 | Accepted code needs a faster line rate |
| code_chg | output | 1 | One-cycle pulse on a new accepted code |
| tx_code | output | 3 | Unfiltered transmit rate code |

## Verification
`rx_code`, `chan_en` and `code_chg` are due at the edge that captures the deciding sample or the preload. The bench drives each input at a falling edge and reads these outputs at the next falling edge. `rate_kbps` and `rate_unsup` come one register later, so the bench waits one more falling edge before checking them. For a `line_sel` change, the bench first confirms that the old rate still holds before the edge, then checks the new rate after it. `tx_code` is combinational and is checked in the same cycle its input changes.

// File: rtl/slowrate_pkg.sv
package slowrate_pkg;

  localparam int CODE_W = 3;
  localparam int RATE_W = 14;
  localparam int LINE_W = 3;

  typedef enum logic [LINE_W-1:0] {
    LR_0614 = 3'd0,
    LR_1228 = 3'd1,
    LR_2457 = 3'd2,
    LR_3072 = 3'd3,
    LR_4915 = 3'd4,
    LR_6144 = 3'd5,
    LR_9830 = 3'd6,
    LR_RSVD = 3'd7
  } line_rate_e;

  // Fixed rate of codes 1..6 (kbps)
  function automatic logic [RATE_W-1:0] fixed_kbps(input logic [CODE_W-1:0] c);
    case (c)
      3'd1:    fixed_kbps = RATE_W'(240);
      3'd2:    fixed_kbps = RATE_W'(480);
      3'd3:    fixed_kbps = RATE_W'(960);
      3'd4:    fixed_kbps = RATE_W'(1920);
      3'd5:    fixed_kbps = RATE_W'(2400);
      3'd6:    fixed_kbps = RATE_W'(3840);
      default: fixed_kbps = '0;
    endcase
  endfunction

  // Lowest line setting that carries a fixed code
  function automatic line_rate_e min_line(input logic [CODE_W-1:0] c);
    case (c)
      3'd3:    min_line = LR_1228;
      3'd4:    min_line = LR_2457;
      3'd5:    min_line = LR_3072;
      3'd6:    min_line = LR_4915;
      default: min_line = LR_0614;
    endcase
  endfunction

  // Fastest slow-channel rate a line setting permits
  function automatic logic [RATE_W-1:0] top_kbps(input line_rate_e l);
    case (l)
      LR_0614: top_kbps = RATE_W'(480);
      LR_1228: top_kbps = RATE_W'(960);
      LR_2457: top_kbps = RATE_W'(1920);
      LR_3072: top_kbps = RATE_W'(2400);
      LR_4915: top_kbps = RATE_W'(3840);
      LR_6144: top_kbps = RATE_W'(4800);
      default: top_kbps = RATE_W'(7680);
    endcase
  endfunction

endpackage

// File: rtl/slowch_code_persist.sv
module slowch_code_persist
  import slowrate_pkg::*;
#(
  parameter int ACCEPT_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              preload_i,
  input  logic [CODE_W-1:0] preload_code_i,
  output logic [CODE_W-1:0] acc_code_o,
  output logic              changed_o
);

  localparam int CNT_W = $clog2(ACCEPT_COUNT + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ACCEPT_COUNT);

  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_sat;
  logic [CODE_W-1:0] last_q, last_d;
  logic [CODE_W-1:0] acc_q, acc_d;
  logic              chg_q, chg_d;
  logic              match;

  always_comb begin
    match   = (cnt_q != '0) && (code_i == last_q);
    cnt_sat = (cnt_q == CNT_FULL) ? cnt_q : CNT_W'(cnt_q + 1'b1);
    cnt_d   = cnt_q;
    last_d  = last_q;
    acc_d   = acc_q;
    chg_d   = 1'b0;
    if (preload_i) begin
      cnt_d = '0;
      acc_d = preload_code_i;
    end else if (sample_i) begin
      last_d = code_i;
      cnt_d  = match ? cnt_sat : CNT_W'(1);
      if (cnt_d == CNT_FULL && code_i != acc_q) begin
        acc_d = code_i;
        chg_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= '0;
      acc_q  <= '0;
      chg_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      last_q <= last_d;
      acc_q  <= acc_d;
      chg_q  <= chg_d;
    end
  end

  assign acc_code_o = acc_q;
  assign changed_o  = chg_q;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  assert_pulse_at_full_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (cnt_q == CNT_FULL));

  assert_pulse_means_new_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (acc_q != $past(acc_q)));

  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_i && !preload_i) |=> $stable(acc_q));

  assert_preload_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    preload_i |=> (!chg_q && acc_q == $past(preload_code_i)));

endmodule

// File: rtl/slowch_rate_resolve.sv
module slowch_rate_resolve
  import slowrate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic [LINE_W-1:0] line_i,
  output logic [RATE_W-1:0] rate_o,
  output logic              unsup_o
);

  line_rate_e        line_eff;
  logic [RATE_W-1:0] rate_d, rate_q;
  logic              unsup_d, unsup_q;

  always_comb begin
    line_eff = (line_i == LR_RSVD) ? LR_9830 : line_rate_e'(line_i);
    rate_d   = '0;
    unsup_d  = 1'b0;
    if (code_i == 3'd7) begin
      rate_d = top_kbps(line_eff);
    end else if (code_i != 3'd0) begin
      if (line_eff < min_line(code_i)) unsup_d = 1'b1;
      else                             rate_d  = fixed_kbps(code_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      unsup_q <= 1'b0;
    end else begin
      rate_q  <= rate_d;
      unsup_q <= unsup_d;
    end
  end

  assign rate_o  = rate_q;
  assign unsup_o = unsup_q;

  assert_unsup_zero_rate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_q |-> (rate_q == '0));

  assert_rate_ceiling_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q <= RATE_W'(7680));

  assert_absent_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == '0) |=> (rate_q == '0 && !unsup_q));

  assert_top_code_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i == 3'd7) |=> (!unsup_q && rate_q >= RATE_W'(480)));

  assert_one_clock_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(code_i) && $stable(line_i)) |=> $stable(rate_q));

endmodule

// File: rtl/slowch_rate_filter.sv
module slowch_rate_filter
  import slowrate_pkg::*;
#(
  parameter int ACCEPT_COUNT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  ctl_byte,
  input  logic        byte_vld,
  input  logic        hf_slot,
  input  logic [2:0]  line_sel,
  input  logic        preload_en,
  input  logic [2:0]  preload_code,
  input  logic [2:0]  tx_cfg_code,
  output logic [2:0]  rx_code,
  output logic        chan_en,
  output logic [13:0] rate_kbps,
  output logic        rate_unsup,
  output logic        code_chg,
  output logic [2:0]  tx_code
);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              sample;
  logic [CODE_W-1:0] acc_code;
  logic              unused_ctl_hi;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign sample        = byte_vld & hf_slot;
  assign unused_ctl_hi = ^ctl_byte[7:CODE_W];

  slowch_code_persist #(
    .ACCEPT_COUNT(ACCEPT_COUNT)
  ) u_persist (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .sample_i      (sample),
    .code_i        (ctl_byte[CODE_W-1:0]),
    .preload_i     (preload_en),
    .preload_code_i(preload_code),
    .acc_code_o    (acc_code),
    .changed_o     (code_chg)
  );

  slowch_rate_resolve u_resolve (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .code_i (acc_code),
    .line_i (line_sel),
    .rate_o (rate_kbps),
    .unsup_o(rate_unsup)
  );

  assign rx_code = acc_code;
  assign chan_en = (acc_code != '0);
  assign tx_code = tx_cfg_code;

  assert_tx_passthrough_R12: assert property (@(posedge clk) disable iff (!rst_core_n)
    tx_code == tx_cfg_code);

  assert_chan_follows_code_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    code_chg |-> (chan_en == (rx_code != 3'd0)));

endmodule

// File: tb/slowch_rate_filter_tb.sv
module slowch_rate_filter_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ctl_byte;
  logic        byte_vld, hf_slot, preload_en;
  logic [2:0]  line_sel, preload_code, tx_cfg_code;
  logic [2:0]  rx_code, tx_code;
  logic        chan_en, rate_unsup, code_chg;
  logic [13:0] rate_kbps;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  slowch_rate_filter u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_byte(ctl_byte), .byte_vld(byte_vld),
    .hf_slot(hf_slot), .line_sel(line_sel), .preload_en(preload_en),
    .preload_code(preload_code), .tx_cfg_code(tx_cfg_code), .rx_code(rx_code),
    .chan_en(chan_en), .rate_kbps(rate_kbps), .rate_unsup(rate_unsup),
    .code_chg(code_chg), .tx_code(tx_code)
  );

  // {code, line, rate, unsup}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {3'd1, 3'd0, 14'd240,  1'b0},
    {3'd2, 3'd0, 14'd480,  1'b0},
    {3'd3, 3'd0, 14'd0,    1'b1},
    {3'd3, 3'd1, 14'd960,  1'b0},
    {3'd4, 3'd2, 14'd1920, 1'b0},
    {3'd5, 3'd2, 14'd0,    1'b1},
    {3'd5, 3'd3, 14'd2400, 1'b0},
    {3'd6, 3'd4, 14'd3840, 1'b0},
    {3'd7, 3'd0, 14'd480,  1'b0},
    {3'd7, 3'd5, 14'd4800, 1'b0},
    {3'd7, 3'd6, 14'd7680, 1'b0},
    {3'd7, 3'd7, 14'd7680, 1'b0},
    {3'd6, 3'd3, 14'd0,    1'b1},
    {3'd0, 3'd6, 14'd0,    1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one sample at a falling edge; return at the falling edge after capture
  task automatic send(input logic [7:0] b, input logic vld = 1'b1, input logic slot = 1'b1);
    ctl_byte = b; byte_vld = vld; hf_slot = slot;
    @(negedge clk);
    byte_vld = 1'b0; hf_slot = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [2:0] acc_model;
    rst_n = 1'b0; ctl_byte = '0; byte_vld = 0; hf_slot = 0;
    line_sel = '0; preload_en = 0; preload_code = '0; tx_cfg_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R5 reset state
    chk("R5 rx_code", rx_code, 0);
    chk("R5 chan_en", chan_en, 0);
    chk("R5 rate", rate_kbps, 0);
    chk("R5 unsup", rate_unsup, 0);
    chk("R5 pulse", code_chg, 0);

    // Vector walk: R2 R4 R6 R7 R8 R9
    acc_model = 3'd0;
    for (int i = 0; i < NV; i++) begin
      logic [2:0] vc; logic [2:0] vl; logic [13:0] vr; logic vu;
      {vc, vl, vr, vu} = VEC[i];
      line_sel = vl;
      for (int k = 0; k < 4; k++) send({5'b0, vc});
      chk("R2 accepted code", rx_code, vc);
      chk("R4 change pulse", code_chg, (vc != acc_model) ? 1 : 0);
      chk("R6 chan_en", chan_en, (vc != 0) ? 1 : 0);
      acc_model = vc;
      @(negedge clk);
      chk("R4 pulse one cycle", code_chg, 0);
      chk((vc == 7) ? "R9 top rate" : "R7/R8 rate", rate_kbps, vr);
      chk("R8 unsupported flag", rate_unsup, vu);
    end

    // R3: interrupted run restarts count
    send(8'd3); send(8'd3); send(8'd3); send(8'd5);
    send(8'd3); send(8'd3); send(8'd3);
    chk("R3 interrupted run not accepted", rx_code, 0);
    send(8'd3);
    chk("R3 fourth after restart accepted", rx_code, 3);

    // R1: unqualified bytes ignored, upper bits ignored
    for (int k = 0; k < 5; k++) send(8'd6, 1'b1, 1'b0);
    for (int k = 0; k < 5; k++) send(8'd6, 1'b0, 1'b1);
    chk("R1 unqualified bytes ignored", rx_code, 3);
    for (int k = 0; k < 4; k++) send(8'hF9);
    chk("R1 upper bits ignored", rx_code, 1);

    // R4: repeat of accepted code gives no pulse
    for (int k = 0; k < 4; k++) begin
      send(8'd1);
      chk("R4 no pulse on repeat", code_chg, 0);
    end
    chk("R4 code held", rx_code, 1);

    // R11: preload, no pulse, run count cleared
    preload_code = 3'd6; preload_en = 1'b1;
    @(negedge clk);
    preload_en = 1'b0;
    chk("R11 preload loads code", rx_code, 6);
    chk("R11 preload no pulse", code_chg, 0);
    send(8'd1); send(8'd1); send(8'd1);
    chk("R11 count cleared by preload", rx_code, 6);
    send(8'd1);
    chk("R11 accepted after fresh run", rx_code, 1);
    // preload beats a simultaneous sample
    preload_code = 3'd4; preload_en = 1'b1;
    send(8'd2);
    preload_en = 1'b0;
    chk("R11 preload priority", rx_code, 4);
    send(8'd2); send(8'd2); send(8'd2);
    chk("R11 same-cycle sample dropped", rx_code, 4);
    send(8'd2);
    chk("R11 run completes after drop", rx_code, 2);

    // R10: line change one clock later (code 6 at setting 4 -> setting 0)
    for (int k = 0; k < 4; k++) send(8'd6);
    line_sel = 3'd4;
    repeat (2) @(negedge clk);
    chk("R10 settled rate", rate_kbps, 3840);
    line_sel = 3'd0;
    #1;
    chk("R10 old rate before edge", rate_kbps, 3840);
    @(negedge clk);
    chk("R10 unsup after one clock", rate_unsup, 1);
    chk("R10 rate forced zero", rate_kbps, 0);

    // R12: transmit code passthrough
    tx_cfg_code = 3'd5;
    #1;
    chk("R12 tx passthrough", tx_code, 5);
    tx_cfg_code = 3'd2;
    send(8'd7);
    chk("R12 tx unaffected by rx", tx_code, 2);

    finish_run();
  end

endmodule